// File: doc/BRIEF.md
# Multicast Window Filter and Overlay Translator

This block sits on one downstream port of a packet switch and looks at every posted memory write headed for that port. It decides whether the write lands inside the configured multicast address window. If it does, the block takes the group number from the address and checks that group against three per-group bit vectors. From that check it either suppresses the write or sends it on. A forwarded multicast write can have its upper address bits replaced by an overlay base, so that it lands in a fixed memory region behind the port. Writes outside the window, or writes seen while multicast is disabled, pass through unchanged on the normal routing path.

Software programs the block through a narrow register write port: a selector picks a register and one data word is written per cycle. Each input write gives one registered result, one cycle later.

Top module: `mcast_port_filter`

## Requirements
- R1: After reset every configuration field is zero and all outputs are low. A write offered before any programming comes out with fwd_valid=1, is_mcast=0 and its address unchanged.
- R2: A configuration write with cfg_we=1 stores cfg_wdata into the register picked by cfg_sel. The selectors are: 0 control, 1 window base, 2 receive vector, 3 block-all vector, 4 block-untranslated vector, 5 overlay size in bits [5:0], 6 overlay base. In the control word, bit 0 is the multicast enable, bits [7:1] are the enabled group count and bits [13:8] are the index position.
- R3: With multicast enabled, the group number is (addr − base) >> index position. A write is a multicast hit when addr ≥ base and the group is below the group count. A count above 64 is treated as 64.
- R4: A write below the base, at a group number at or above the count, or seen while the enable is clear is not a hit. It gives is_mcast=0, fwd_valid=1 and the same address.
- R5: A hit is forwarded only when the receive bit of its group is set. Otherwise the output is dropped=1 and fwd_valid=0.
- R6: A set block-all bit drops a hit to that group whatever the receive bit is.
- R7: A set block-untranslated bit drops a hit to that group only when in_untrans=1.
- R8: A forwarded hit with overlay size S in 6..63 leaves with the overlay base in address bits S and above, and its own bits below S.
- R9: An overlay size below 6 leaves the hit's address unchanged.
- R10: Outputs are registered one cycle after the input. A cycle with in_valid=0 gives fwd_valid=0, is_mcast=0 and dropped=0 in the following cycle.
- R11: fwd_valid and dropped are never high together, and dropped only appears with is_mcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register selector |
| cfg_wdata | input | 64 | Configuration write data |
| in_valid | input | 1 | Posted write present this cycle |
| in_addr | input | 64 | Write address |
| in_untrans | input | 1 | Address is untranslated |
| fwd_valid | output | 1 | Write is forwarded out of the port |
| fwd_addr | output | 64 | Forwarded (possibly overlaid) address |
| is_mcast | output | 1 | Write was a multicast hit |
| dropped | output | 1 | Multicast hit suppressed by the vectors |

## Verification
The hardest case to reach from the ports is the edge of the window. That means the last address of the highest enabled group, the first address past it, and a group count written above 64. Random addresses with a random index position almost never land exactly there. So directed cases place addresses at base−1, at the top of group count−1 and at group count × stride, alongside random groups. Random vectors and random untranslated flags also cover the case where block-all and block-untranslated are set on the same group as the receive bit.

// File: rtl/mcast_pkg.sv
package mcast_pkg;
    localparam int ADDR_W  = 64;
    localparam int MAX_GRP = 64;
    localparam int GIDX_W  = $clog2(MAX_GRP);
    localparam int CNT_W   = GIDX_W + 1;
    localparam int POS_W   = $clog2(ADDR_W);
    localparam int OVL_MIN = 6;
    localparam int SEL_W   = 3;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [MAX_GRP-1:0] gvec_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL    = 3'd0,
        SEL_BASE    = 3'd1,
        SEL_RX      = 3'd2,
        SEL_BLKALL  = 3'd3,
        SEL_BLKUT   = 3'd4,
        SEL_OVLSZ   = 3'd5,
        SEL_OVLBASE = 3'd6
    } sel_e;

    typedef struct packed {
        logic              en;
        logic [CNT_W-1:0]  ngrp;
        logic [POS_W-1:0]  idx_pos;
        addr_t             base;
        gvec_t             rx;
        gvec_t             blk_all;
        gvec_t             blk_ut;
        logic [POS_W-1:0]  ovl_size;
        addr_t             ovl_base;
    } cfg_t;

    typedef struct packed {
        logic  fwd_valid;
        addr_t fwd_addr;
        logic  is_mcast;
        logic  dropped;
    } out_t;
endpackage

// File: rtl/mcast_cfg_regs.sv
module mcast_cfg_regs
    import mcast_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  addr_t            cfg_wdata,
    output cfg_t             cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            case (sel_e'(cfg_sel))
                SEL_CTRL: begin
                    cfg_d.en      = cfg_wdata[0];
                    cfg_d.ngrp    = cfg_wdata[CNT_W:1];
                    cfg_d.idx_pos = cfg_wdata[8+POS_W-1:8];
                end
                SEL_BASE:    cfg_d.base     = cfg_wdata;
                SEL_RX:      cfg_d.rx       = cfg_wdata[MAX_GRP-1:0];
                SEL_BLKALL:  cfg_d.blk_all  = cfg_wdata[MAX_GRP-1:0];
                SEL_BLKUT:   cfg_d.blk_ut   = cfg_wdata[MAX_GRP-1:0];
                SEL_OVLSZ:   cfg_d.ovl_size = cfg_wdata[POS_W-1:0];
                SEL_OVLBASE: cfg_d.ovl_base = cfg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q)); // R2
endmodule

// File: rtl/mcast_decode.sv
module mcast_decode
    import mcast_pkg::*;
(
    input  cfg_t  cfg,
    input  addr_t addr,
    input  logic  untrans,
    output logic  hit,
    output logic  pass,
    output addr_t xaddr
);
    addr_t             offset;
    addr_t             shifted;
    addr_t             mask;
    logic [CNT_W-1:0]  ngrp_c;
    logic [GIDX_W-1:0] grp;

    always_comb begin
        offset  = addr - cfg.base;
        shifted = offset >> cfg.idx_pos;
        ngrp_c  = (cfg.ngrp > CNT_W'(MAX_GRP)) ? CNT_W'(MAX_GRP) : cfg.ngrp;
        hit     = cfg.en && (addr >= cfg.base) && (shifted < ADDR_W'(ngrp_c));
        grp     = shifted[GIDX_W-1:0];
        pass    = cfg.rx[grp] && !cfg.blk_all[grp] && !(untrans && cfg.blk_ut[grp]);
        if (cfg.ovl_size >= POS_W'(OVL_MIN))
            mask = (addr_t'(1) << cfg.ovl_size) - addr_t'(1);
        else
            mask = '1;
        xaddr   = (cfg.ovl_base & ~mask) | (addr & mask);
    end
endmodule

// File: rtl/mcast_port_filter.sv
module mcast_port_filter
    import mcast_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_sel,
    input  logic [63:0] cfg_wdata,
    input  logic        in_valid,
    input  logic [63:0] in_addr,
    input  logic        in_untrans,
    output logic        fwd_valid,
    output logic [63:0] fwd_addr,
    output logic        is_mcast,
    output logic        dropped
);
    cfg_t  cfg;
    logic  hit, pass;
    addr_t xaddr;
    out_t  out_d, out_q;

    mcast_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg)
    );

    mcast_decode u_dec (
        .cfg     (cfg),
        .addr    (in_addr),
        .untrans (in_untrans),
        .hit     (hit),
        .pass    (pass),
        .xaddr   (xaddr)
    );

    always_comb begin
        out_d           = out_q;
        out_d.fwd_valid = 1'b0;
        out_d.is_mcast  = 1'b0;
        out_d.dropped   = 1'b0;
        if (in_valid) begin
            if (hit) begin
                out_d.is_mcast  = 1'b1;
                out_d.fwd_valid = pass;
                out_d.dropped   = !pass;
                out_d.fwd_addr  = xaddr;
            end else begin
                out_d.fwd_valid = 1'b1;
                out_d.fwd_addr  = in_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign fwd_valid = out_q.fwd_valid;
    assign fwd_addr  = out_q.fwd_addr;
    assign is_mcast  = out_q.is_mcast;
    assign dropped   = out_q.dropped;

    AST_DROP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_valid && dropped)); // R11
    AST_DROP_MCAST: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |-> is_mcast); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!fwd_valid && !dropped && !is_mcast)); // R10
    AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg.en) |=> (fwd_valid && !is_mcast && fwd_addr == $past(in_addr))); // R4
    AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (fwd_addr[OVL_MIN-1:0] == $past(in_addr[OVL_MIN-1:0]))); // R8
endmodule

// File: tb/mcast_port_filter_bench.sv
`timescale 1ns/1ps
module mcast_port_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [63:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic [63:0] in_addr = '0;
    logic        in_untrans = 1'b0;
    logic        fwd_valid, is_mcast, dropped;
    logic [63:0] fwd_addr;

    int n_run = 0;
    int n_fail = 0;

    // bench-side copy of the programmed configuration
    logic        m_en = 0;
    int          m_ngrp = 0;
    int          m_idx = 0;
    logic [63:0] m_base = 0, m_rx = 0, m_ba = 0, m_bu = 0, m_obase = 0;
    int          m_osz = 0;

    always #4 clk = ~clk;

    mcast_port_filter u_mcast_port_filter (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_addr(in_addr),
        .in_untrans(in_untrans), .fwd_valid(fwd_valid), .fwd_addr(fwd_addr),
        .is_mcast(is_mcast), .dropped(dropped)
    );

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    task automatic chk(input string req, input logic [66:0] act, input logic [66:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wcfg(input int sel, input logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            0: begin m_en = d[0]; m_ngrp = int'(d[7:1]); m_idx = int'(d[13:8]); end
            1: m_base = d;
            2: m_rx = d;
            3: m_ba = d;
            4: m_bu = d;
            5: m_osz = int'(d[5:0]);
            6: m_obase = d;
            default: ;
        endcase
    endtask

    task automatic setup(input logic en, input int ng, input int ip);
        wcfg(0, {50'd0, 6'(ip), 7'(ng), en});
    endtask

    // expected {fwd_valid, is_mcast, dropped, fwd_addr}
    function automatic logic [66:0] model(input logic [63:0] a, input logic u);
        int          lim;
        logic [63:0] g;
        logic [63:0] keep;
        logic        ok;
        lim = (m_ngrp > 64) ? 64 : m_ngrp;
        if (!m_en || a < m_base) return {3'b100, a};
        g = (a - m_base) >> m_idx;
        if (g >= 64'(lim)) return {3'b100, a};
        ok = m_rx[g[5:0]] && !m_ba[g[5:0]] && !(u && m_bu[g[5:0]]);
        if (!ok) return {3'b011, fwd_addr};
        if (m_osz < 6) return {3'b110, a};
        keep = (64'd1 << m_osz) - 64'd1;
        return {3'b110, (m_obase & ~keep) | (a & keep)};
    endfunction

    task automatic send(input string req, input logic [63:0] a, input logic u);
        logic [66:0] exp;
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_untrans = u;
        exp = model(a, u);
        @(negedge clk);
        if (exp[64]) exp[63:0] = fwd_addr; // address is don't-care on a drop
        chk(req, {fwd_valid, is_mcast, dropped, fwd_addr}, exp);
        in_valid = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {fwd_valid, is_mcast, dropped, fwd_addr}, '0);
        rst_n = 1'b1;
        send("R1 unprogrammed passes", 64'h4_7000_0abc, 1'b0);
        // idle cycle
        @(negedge clk);
        chk("R10 idle quiet", {fwd_valid, is_mcast, dropped}, 3'b000);

        // worked example: one group, 4 KiB stride, 64 KiB overlay
        wcfg(1, 64'h4_7000_0000);
        wcfg(2, 64'h1);
        wcfg(5, 64'd16);
        wcfg(6, 64'h4_7200_0000);
        send("R4 enable clear", 64'h4_7000_0abc, 1'b0);
        setup(1'b1, 1, 12);
        send("R8 overlay rewrite", 64'h4_7000_0abc, 1'b0);
        chk("R8 overlay address", {3'b0, fwd_addr}, {3'b0, 64'h4_7200_0abc});
        send("R3 last byte of group", 64'h4_7000_0fff, 1'b1);
        send("R4 group past count", 64'h4_7000_1000, 1'b0);
        send("R4 below base", 64'h4_6fff_ffff, 1'b0);
        wcfg(5, 64'd5);
        send("R9 small overlay", 64'h4_7000_0123, 1'b0);
        chk("R9 address kept", {3'b0, fwd_addr}, {3'b0, 64'h4_7000_0123});
        wcfg(2, 64'h0);
        send("R5 receive bit clear", 64'h4_7000_0010, 1'b0);
        chk("R5 dropped", {1'b0, fwd_valid, dropped}, 3'b001);
        wcfg(2, 64'h1);
        wcfg(3, 64'h1);
        send("R6 block-all", 64'h4_7000_0010, 1'b0);
        wcfg(3, 64'h0);
        wcfg(4, 64'h1);
        send("R7 untranslated blocked", 64'h4_7000_0010, 1'b1);
        send("R7 translated passes", 64'h4_7000_0010, 1'b0);
        // count above 64 clamps
        wcfg(0, {50'd0, 6'd8, 7'd100, 1'b1});
        wcfg(2, '1);
        send("R3 group 63 hits", 64'h4_7000_0000 + 64'd63 * 256, 1'b0);
        send("R3 clamp group 64", 64'h4_7000_0000 + 64'd64 * 256, 1'b0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            if (i % 20 == 0) begin
                wcfg(1, {16'd0, $urandom(), 16'(0)} & ~64'hfff);
                wcfg(2, {$urandom(), $urandom()});
                wcfg(3, {$urandom(), $urandom()} & {$urandom(), $urandom()});
                wcfg(4, {$urandom(), $urandom()});
                wcfg(5, 64'($urandom_range(0, 40)));
                wcfg(6, {$urandom(), $urandom()});
                setup(1'b1, int'($urandom_range(1, 70)), int'($urandom_range(6, 20)));
            end
            begin
                logic [63:0] a;
                int sel;
                sel = int'($urandom_range(0, 9));
                if (sel == 0)
                    a = m_base - 64'd1;
                else if (sel == 1)
                    a = m_base + (64'((m_ngrp > 64) ? 64 : m_ngrp) << m_idx);
                else if (sel == 2)
                    a = m_base + (64'((m_ngrp > 64) ? 64 : m_ngrp) << m_idx) - 64'd1;
                else
                    a = m_base + (64'($urandom_range(0, 66)) << m_idx) +
                        64'($urandom_range(0, (1 << m_idx) - 1));
                send("R3 R5 R6 R7 R8 random", a, 1'($urandom()));
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule